// File: doc/BRIEF.md
# Peripheral Trigger Output Stage

This block is the last stage between an event sequencer and the peripherals it drives. The sequencer issues a request strobe together with a 4-bit option code. The block turns each request into activity on a bank of sixteen trigger lines. An option code from 0 to 14 names one line. The all-ones code fires every line whose bit is set in a broadcast mask, all on the same clock edge.

A global mode input chooses how a fired line behaves. In level-flip mode the line changes to the opposite level and keeps it. In pulse mode the line goes high for a programmable number of clocks. Each line has its own small state machine and width counter, so pulses on different lines run independently. A second request to a line that is already pulsing starts its width count again.

A separate literal path copies a literal value onto a channel-select data bus when the literal strobe is seen. It raises a one-cycle write enable with the data.

Each trigger line has three states:
- LN_LOW: the output is low.
- LN_HIGH: the output is held high in level-flip mode.
- LN_PULSE: the output is high while the width counter runs down.

The line transitions are:
- low-to-high: a hit in level-flip mode.
- high-to-low: a hit in level-flip mode.
- any-to-pulse: a hit in pulse mode, which also loads the counter.
- pulse-restart: a hit in pulse mode while in LN_PULSE, which reloads the counter.
- pulse-expire: LN_PULSE with the counter at zero and no hit, which returns to LN_LOW.
- pulse-to-low: a hit in level-flip mode while in LN_PULSE.

The literal path has two states:
- WR_IDLE: no write is in progress.
- WR_ACTIVE: the write enable is high.

It enters WR_ACTIVE on a cycle in which the literal strobe is high. It returns to WR_IDLE otherwise.

Top module: `trig_fanout`

## Requirements
- R1: While reset is asserted and after it is released, all trigger lines are low, the write enable is low and the channel-select data is zero, until the first request or strobe.
- R2: A request with an option code k from 0 to 14 acts on trigger line k only. All other lines keep their current behaviour.
- R3: A request with option code 4'b1111 acts at once on every line i whose broadcast mask bit i is 1. Lines whose mask bit is 0 are unaffected.
- R4: When the mode input is 0 (level-flip), every line hit by a request inverts its level exactly once. The new level appears right after the clock edge that samples the request.
- R5: When the mode input is 1 (pulse), a hit line goes high right after the edge that samples the request. It stays high for exactly W+1 clock cycles, where W is the pulse-width input, and then returns low.
- R6: In pulse mode, a new hit on a line that is already pulsing restarts its count. The line then stays high for W+1 cycles counted from the new request.
- R7: A cycle with the literal strobe high loads the literal value onto the channel-select data bus. The write enable is high for the following cycle only, and the data holds until the next strobe.
- R8: With no request, a line in level-flip state keeps its level indefinitely.
- R9: The broadcast mask has no effect on requests with option codes 0 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Trigger request strobe |
| req_opt | input | 4 | Option code: 0..14 selects one line, 15 broadcasts |
| bcast_mask | input | 16 | Lines fired by a broadcast request |
| pulse_mode | input | 1 | 0 = level-flip, 1 = pulse |
| pulse_width | input | 8 | Pulse length minus one, in clocks |
| lit_value | input | 16 | Literal for the channel-select bus |
| lit_strobe | input | 1 | Copy the literal and raise the write enable |
| trig_out | output | 16 | Trigger lines |
| chsel_data | output | 16 | Channel-select data |
| chsel_we | output | 1 | Channel-select write enable |

## Verification
The bench sweeps every single-line option code with a broadcast mask that is deliberately nonzero. A decoder that let the mask leak into single-line requests, or that mis-decoded one code, would change the wrong bits. It also applies several broadcast masks, including empty and full ones; a decoder that fired line 15 on a single code, or that ignored the mask, would show up there. Pulse lengths are measured for widths 0 to 6 on several lines, which exposes off-by-one errors in the counter. A retrigger in the middle of a pulse checks that the count restarts rather than running out early. The literal path is checked for a write enable that stays high for more than one cycle, and for data that does not hold after the strobe.

// File: rtl/trig_fanout_pkg.sv
package trig_fanout_pkg;
    typedef enum logic [1:0] {
        LN_LOW   = 2'd0,
        LN_HIGH  = 2'd1,
        LN_PULSE = 2'd2
    } line_st_e;

    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_ACTIVE = 1'b1
    } wr_st_e;
endpackage

// File: rtl/trig_decode.sv
module trig_decode #(
    parameter int N_TRIG = 16,
    parameter int OPT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OPT_W-1:0]  req_opt,
    input  logic [N_TRIG-1:0] bcast_mask,
    output logic [N_TRIG-1:0] hit
);
    localparam logic [OPT_W-1:0] BCAST_CODE = {OPT_W{1'b1}};

    for (genvar i = 0; i < N_TRIG; i++) begin : g_hit
        always_comb begin
            if (!req_valid)
                hit[i] = 1'b0;
            else if (req_opt == BCAST_CODE)
                hit[i] = bcast_mask[i];
            else
                hit[i] = (req_opt == OPT_W'(i));
        end
    end

    // R2, R9: a non-broadcast request reaches exactly one line
    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opt != BCAST_CODE) |-> $countones(hit) == 1);

    // R3: a broadcast never hits a line outside the mask
    assert_bcast_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opt == BCAST_CODE) |-> (hit & ~bcast_mask) == '0);
endmodule

// File: rtl/trig_line.sv
module trig_line
    import trig_fanout_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            pulse_mode,
    input  logic [PW_W-1:0] width,
    output logic            level
);
    line_st_e        st, st_nxt;
    logic [PW_W-1:0] cnt, cnt_nxt;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            LN_LOW: begin
                if (hit) begin
                    if (pulse_mode) begin
                        st_nxt  = LN_PULSE;
                        cnt_nxt = width;
                    end else begin
                        st_nxt = LN_HIGH;
                    end
                end
            end
            LN_HIGH: begin
                if (hit) begin
                    if (pulse_mode) begin
                        st_nxt  = LN_PULSE;
                        cnt_nxt = width;
                    end else begin
                        st_nxt = LN_LOW;
                    end
                end
            end
            LN_PULSE: begin
                if (hit) begin
                    if (pulse_mode) cnt_nxt = width;
                    else            st_nxt  = LN_LOW;
                end else if (cnt == '0) begin
                    st_nxt = LN_LOW;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: st_nxt = LN_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LN_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level <= 1'b0;
        else        level <= (st_nxt != LN_LOW);
    end

    // R4: level-flip hit inverts the line
    assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pulse_mode) |=> level != $past(level));

    // R5: pulse hit drives the line high
    assert_pulse_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pulse_mode) |=> level);

    // R8: outside a pulse, no hit means no change
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && st != LN_PULSE) |=> $stable(level));
endmodule

// File: rtl/chsel_strobe.sv
module chsel_strobe
    import trig_fanout_pkg::*;
#(
    parameter int LIT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lit_strobe,
    input  logic [LIT_W-1:0] lit_value,
    output logic [LIT_W-1:0] chsel_data,
    output logic             chsel_we
);
    wr_st_e st, st_nxt;

    always_comb begin
        unique case (st)
            WR_IDLE:   st_nxt = lit_strobe ? WR_ACTIVE : WR_IDLE;
            WR_ACTIVE: st_nxt = lit_strobe ? WR_ACTIVE : WR_IDLE;
            default:   st_nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WR_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chsel_data <= '0;
            chsel_we   <= 1'b0;
        end else begin
            chsel_we <= (st_nxt == WR_ACTIVE);
            if (lit_strobe) chsel_data <= lit_value;
        end
    end

    // R7: strobe produces the write with the sampled literal
    assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lit_strobe |=> (chsel_we && chsel_data == $past(lit_value)));

    // R7: no strobe, no write and data held
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lit_strobe |=> (!chsel_we && $stable(chsel_data)));
endmodule

// File: rtl/trig_fanout.sv
module trig_fanout #(
    parameter int N_TRIG = 16,
    parameter int OPT_W  = 4,
    parameter int PW_W   = 8,
    parameter int LIT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OPT_W-1:0]  req_opt,
    input  logic [N_TRIG-1:0] bcast_mask,
    input  logic              pulse_mode,
    input  logic [PW_W-1:0]   pulse_width,
    input  logic [LIT_W-1:0]  lit_value,
    input  logic              lit_strobe,
    output logic [N_TRIG-1:0] trig_out,
    output logic [LIT_W-1:0]  chsel_data,
    output logic              chsel_we
);
    logic [N_TRIG-1:0] hit;

    trig_decode #(.N_TRIG(N_TRIG), .OPT_W(OPT_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_opt    (req_opt),
        .bcast_mask (bcast_mask),
        .hit        (hit)
    );

    for (genvar i = 0; i < N_TRIG; i++) begin : g_line
        trig_line #(.PW_W(PW_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit[i]),
            .pulse_mode (pulse_mode),
            .width      (pulse_width),
            .level      (trig_out[i])
        );
    end

    chsel_strobe #(.LIT_W(LIT_W)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lit_strobe (lit_strobe),
        .lit_value  (lit_value),
        .chsel_data (chsel_data),
        .chsel_we   (chsel_we)
    );
endmodule

// File: tb/trig_fanout_bench.sv
module trig_fanout_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_opt = '0;
    logic [15:0] bcast_mask = '0;
    logic        pulse_mode = 1'b0;
    logic [7:0]  pulse_width = '0;
    logic [15:0] lit_value = '0;
    logic        lit_strobe = 1'b0;
    logic [15:0] trig_out;
    logic [15:0] chsel_data;
    logic        chsel_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_fanout u_trig_fanout (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opt(req_opt),
        .bcast_mask(bcast_mask), .pulse_mode(pulse_mode), .pulse_width(pulse_width),
        .lit_value(lit_value), .lit_strobe(lit_strobe), .trig_out(trig_out),
        .chsel_data(chsel_data), .chsel_we(chsel_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, leave at the next falling edge (one rising edge sampled)
    task automatic req(input logic [3:0] opt);
        @(negedge clk);
        req_valid = 1'b1;
        req_opt   = opt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic count_high(input int line, output int n);
        n = 0;
        while (trig_out[line] && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] prev;
        logic [15:0] masks [5];
        int n;
        masks[0] = 16'h8001; masks[1] = 16'h0F0F; masks[2] = 16'hFFFF;
        masks[3] = 16'h0000; masks[4] = 16'h70F1;

        repeat (3) @(negedge clk);
        chk("R1 reset lines", 32'(trig_out), 32'h0);
        chk("R1 reset we", 32'(chsel_we), 32'h0);
        chk("R1 reset data", 32'(chsel_data), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after release", 32'(trig_out), 32'h0);

        // R2, R4, R9: level-flip sweep of every single-line code with a junk mask
        bcast_mask = 16'hA5C3;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 15; k++) begin
                prev = trig_out;
                req(4'(k));
                chk("R2/R4/R9 single flip", 32'(trig_out), 32'(prev ^ (16'h1 << k)));
            end
        end
        chk("R4 double sweep returns low", 32'(trig_out), 32'h0);

        // R8: hold with no requests
        req(4'd3);
        prev = trig_out;
        repeat (7) @(negedge clk);
        chk("R8 hold", 32'(trig_out), 32'(prev));
        req(4'd3);

        // R3: broadcast masks, ending at zero
        for (int m = 0; m < 5; m++) begin
            bcast_mask = masks[m];
            prev = trig_out;
            req(4'hF);
            chk("R3 broadcast", 32'(trig_out), 32'(prev ^ masks[m]));
        end
        chk("R3 final all low", 32'(trig_out), 32'h0);

        // R5: pulse length sweep
        pulse_mode = 1'b1;
        bcast_mask = 16'hFFFF;
        for (int w = 0; w < 7; w++) begin
            for (int li = 0; li < 3; li++) begin
                int line;
                line = (li == 0) ? 0 : (li == 1) ? 7 : 14;
                pulse_width = 8'(w);
                req(4'(line));
                chk("R5 only target high", 32'(trig_out), 32'(16'h1 << line));
                count_high(line, n);
                chk("R5 pulse length", 32'(n), 32'(w + 1));
            end
        end

        // R3 + R5: broadcast pulse
        pulse_width = 8'd3;
        bcast_mask = 16'h8421;
        req(4'hF);
        for (int c = 0; c < 4; c++) begin
            chk("R3/R5 broadcast pulse", 32'(trig_out), 32'h8421);
            @(negedge clk);
        end
        chk("R5 broadcast pulse end", 32'(trig_out), 32'h0);

        // R6: restart during a pulse
        pulse_width = 8'd4;
        req(4'd5);
        repeat (2) @(negedge clk);
        chk("R6 still high before retrigger", 32'(trig_out[5]), 32'h1);
        req(4'd5);
        count_high(5, n);
        chk("R6 restarted length", 32'(n), 32'd5);

        // R7: literal strobe sweep
        for (int v = 0; v < 16; v++) begin
            logic [15:0] val;
            val = 16'(v * 16'h1111) ^ 16'h5A3C;
            @(negedge clk);
            lit_value = val;
            lit_strobe = 1'b1;
            @(negedge clk);
            lit_strobe = 1'b0;
            lit_value = ~val;
            chk("R7 write enable", 32'(chsel_we), 32'h1);
            chk("R7 data", 32'(chsel_data), 32'(val));
            @(negedge clk);
            chk("R7 enable one cycle", 32'(chsel_we), 32'h0);
            chk("R7 data held", 32'(chsel_data), 32'(val));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule